// File: doc/BRIEF.md
# Dual-Lane Division/Remainder Word Mixer

This block scrambles a pair of 64-bit words with integer division. It processes each word in its own lane. A lane forms two operands from its word: the bitwise complement, and the word with its eight bytes in reverse order. The lane divides the larger operand by the smaller one. It then hands its remainder to the other lane. Each output word is the original word minus the sum of its own quotient and the remainder of the other lane. All arithmetic is unsigned and wraps modulo 2^64.

A caller places both words on the inputs and pulses `start`. The two lanes run restoring shift-subtract dividers in parallel, at one quotient bit per cycle. A one-cycle `done` pulse marks the moment both updated words are on the outputs. The results stay there until a later operation completes. The latency is fixed and does not depend on the data. This includes the case where an operand is zero.

Top module: `divmix_dual`

## Requirements
- R1: For each lane, the operands are P = ~word and Q = the word with byte k moved to byte 7-k, for k = 0..7.
- R2: If P or Q of a lane is zero, that lane's quotient and remainder are both taken as zero.
- R3: When P > Q, the lane computes quotient = P / Q and remainder = P mod Q.
- R4: When P <= Q, the lane computes quotient = Q / P and remainder = Q mod P. When P equals Q, this gives quotient 1 and remainder 0.
- R5: Lane 0's quotient is increased by lane 1's remainder, and lane 1's quotient by lane 0's remainder. Both additions use the unadjusted remainders.
- R6: v0_out = v0_in - adjusted lane-0 quotient, and v1_out = v1_in - adjusted lane-1 quotient, modulo 2^64.
- R7: Suppose start is sampled at clock edge E. Then done is high for exactly one cycle, after edge E+W+1, where W = 64.
- R8: A start pulse that arrives while an operation is in flight is ignored. v0_out and v1_out change only in the cycle where done is high, and otherwise hold their values.
- R9: busy is high from the edge that accepts start until the edge that raises done, and is never high together with done. After reset, busy, done and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation on v0_in/v1_in (accepted only when idle) |
| v0_in | input | 64 | Lane-0 word, captured at start |
| v1_in | input | 64 | Lane-1 word, captured at start |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle pulse: outputs just updated |
| v0_out | output | 64 | Updated lane-0 word |
| v1_out | output | 64 | Updated lane-1 word |

## Verification
The assertions assume three things about the inputs: `start` is a clean synchronous level, the input words need to be valid only in the cycle where start is accepted, and reset is asserted before the first operation. The stimulus holds data steady around each accepted start and later changes the inputs freely. It also fires a second start while the first operation is still running, to show that the captured words alone decide the result. The vectors include words whose operands compare greater, smaller and equal, as well as words that make an operand zero. This means each divider invariant is exercised, including the guard against a zero divisor.

// File: rtl/divmix_pkg.sv
package divmix_pkg;
  parameter int unsigned MIX_W = 64;

  typedef enum logic [0:0] {
    LN_IDLE = 1'b0,
    LN_RUN  = 1'b1
  } lane_state_e;
endpackage

// File: rtl/divmix_lane.sv
module divmix_lane
  import divmix_pkg::*;
#(
  parameter int unsigned W = MIX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word_in,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int unsigned NB = W / 8;
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef struct packed {
    logic [W:0]   part;
    logic [W-1:0] qbits;
  } step_t;

  function automatic logic [W-1:0] flip_bytes(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < NB; k++) r[8*k +: 8] = v[8*(NB-1-k) +: 8];
    return r;
  endfunction

  function automatic step_t div_step(input logic [W:0] part,
                                     input logic [W-1:0] qbits,
                                     input logic [W-1:0] dv);
    step_t      s;
    logic [W:0] shifted;
    shifted = {part[W-1:0], qbits[W-1]};
    if (shifted >= {1'b0, dv}) begin
      s.part  = shifted - {1'b0, dv};
      s.qbits = {qbits[W-2:0], 1'b1};
    end else begin
      s.part  = shifted;
      s.qbits = {qbits[W-2:0], 1'b0};
    end
    return s;
  endfunction

  lane_state_e  st_q;
  logic [W:0]   part_q;
  logic [W-1:0] qbits_q, dvsr_q, big_q;
  logic [CW-1:0] cnt_q;
  logic         zero_q, fin_q;

  logic [W-1:0] op_p, op_q;
  logic         op_zero, p_bigger;
  step_t        nxt;
  logic         lane_step, lane_last;

  assign op_p     = ~word_in;
  assign op_q     = flip_bytes(word_in);
  assign op_zero  = (op_p == '0) || (op_q == '0);
  assign p_bigger = op_p > op_q;
  assign nxt      = div_step(part_q, qbits_q, dvsr_q);
  assign lane_step = (st_q == LN_RUN);
  assign lane_last = lane_step && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LN_IDLE;
      part_q  <= '0;
      qbits_q <= '0;
      dvsr_q  <= '0;
      big_q   <= '0;
      cnt_q   <= '0;
      zero_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load && st_q == LN_IDLE) begin
        st_q    <= LN_RUN;
        part_q  <= '0;
        cnt_q   <= '0;
        zero_q  <= op_zero;
        qbits_q <= p_bigger ? op_p : op_q;
        big_q   <= p_bigger ? op_p : op_q;
        dvsr_q  <= p_bigger ? op_q : op_p;
      end else if (lane_step) begin
        part_q  <= nxt.part;
        qbits_q <= nxt.qbits;
        cnt_q   <= cnt_q + 1'b1;
        if (lane_last) begin
          st_q  <= LN_IDLE;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin = fin_q;
  assign quo = zero_q ? '0 : qbits_q;
  assign rem = zero_q ? '0 : part_q[W-1:0];

  AST_NONZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    lane_step |-> (zero_q || dvsr_q != '0)); // R2
  AST_DIVIDEND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    lane_step |-> (big_q >= dvsr_q)); // R3
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && !zero_q) |-> (part_q[W-1:0] < dvsr_q)); // R4
  AST_PART_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_step && !zero_q && cnt_q != '0) |-> (part_q < {1'b0, dvsr_q})); // R3
endmodule

// File: rtl/divmix_dual.sv
module divmix_dual
  import divmix_pkg::*;
#(
  parameter int unsigned W = MIX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] v0_in,
  input  logic [W-1:0] v1_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] v0_out,
  output logic [W-1:0] v1_out
);
  localparam int unsigned LANES = 2;

  function automatic logic [W-1:0] mix_sub(input logic [W-1:0] w,
                                           input logic [W-1:0] q,
                                           input logic [W-1:0] r);
    return w - (q + r);
  endfunction

  logic [W-1:0] word_in [LANES];
  logic [W-1:0] held    [LANES];
  logic [W-1:0] quo     [LANES];
  logic [W-1:0] rem     [LANES];
  logic [LANES-1:0] fin;

  logic busy_q, done_q, accept, all_fin;
  logic [W-1:0] v0_q, v1_q;

  assign accept     = start && !busy_q;
  assign all_fin    = &fin;
  assign word_in[0] = v0_in;
  assign word_in[1] = v1_in;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    divmix_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .word_in (word_in[i]),
      .fin     (fin[i]),
      .quo     (quo[i]),
      .rem     (rem[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held[i] <= '0;
      else if (accept) held[i] <= word_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      v0_q   <= '0;
      v1_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) busy_q <= 1'b1;
      if (all_fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        v0_q   <= mix_sub(held[0], quo[0], rem[1]);
        v1_q   <= mix_sub(held[1], quo[1], rem[0]);
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign v0_out = v0_q;
  assign v1_out = v1_q;

  AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    fin[0] == fin[1]); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable({v0_q, v1_q})); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !all_fin) |=> busy_q); // R8
endmodule

// File: tb/tb_divmix_dual.sv
module tb_divmix_dual;
  localparam int unsigned W = 64;
  localparam int LAT = W + 2;
  localparam int NV = 8;
  localparam logic [63:0] VA [NV] = '{
    64'h0123456789ABCDEF, 64'h0000000000000001, 64'hFFFFFFFFFFFFFF00,
    64'hDEADBEEFCAFEF00D, 64'h8000000000000000, 64'h00000000000000FF,
    64'h7F7F7F7F01010101, 64'h1234000000005678};
  localparam logic [63:0] VB [NV] = '{
    64'hFEDCBA9876543210, 64'hFFFFFFFFFFFFFF00, 64'h0000000000000001,
    64'h0F1E2D3C4B5A6978, 64'h00000000000000FF, 64'h8000000000000000,
    64'hA5A5A5A55A5A5A5A, 64'h0000000100000002};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] v0_in = '0, v1_in = '0;
  logic busy, done;
  logic [63:0] v0_out, v1_out;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  divmix_dual #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .v0_in(v0_in), .v1_in(v1_in),
    .busy(busy), .done(done), .v0_out(v0_out), .v1_out(v1_out));

  function automatic logic [63:0] rev8(input logic [63:0] v);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) r = (r << 8) | ((v >> (8 * k)) & 64'hFF);
    return r;
  endfunction

  task automatic lane_ref(input logic [63:0] v, output logic [63:0] q, output logic [63:0] r);
    logic [63:0] a, b;
    a = ~v; b = rev8(v);
    if (a == 0 || b == 0) begin q = 0; r = 0; end
    else if (a > b) begin q = a / b; r = a % b; end
    else begin q = b / a; r = b % a; end
  endtask

  task automatic model(input logic [63:0] a, b, output logic [63:0] ea, eb);
    logic [63:0] q0, r0, q1, r1;
    lane_ref(a, q0, r0);
    lane_ref(b, q1, r1);
    ea = a - (q0 + r1);
    eb = b - (q1 + r0);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, output int lat);
    @(negedge clk); v0_in = a; v1_in = b; start = 1'b1;
    @(negedge clk); start = 1'b0; v0_in = ~a; v1_in = ~b; lat = 1;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] ea, eb, h0, h1;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {63'd0, busy}, 64'd0);
    chk("R9 reset done", {63'd0, done}, 64'd0);
    chk("R9 reset out0", v0_out, 64'd0);
    chk("R9 reset out1", v1_out, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VA[i], VB[i], lat);
      model(VA[i], VB[i], ea, eb);
      chk("R1 R3 R4 R5 R6 v0", v0_out, ea);
      chk("R1 R3 R4 R5 R6 v1", v1_out, eb);
      chk("R7 latency", 64'(lat), 64'(LAT));
      @(negedge clk);
      chk("R7 one-cycle done", {63'd0, done}, 64'd0);
    end

    // R2: all-ones word gives P = 0; zero word gives Q = 0
    run_op(64'hFFFFFFFFFFFFFFFF, 64'h0, lat);
    chk("R2 zero lane v0", v0_out, 64'hFFFFFFFFFFFFFFFF);
    chk("R2 zero lane v1", v1_out, 64'h0);
    chk("R2 latency fixed R7", 64'(lat), 64'(LAT));

    // R4: P equals Q -> quotient 1, remainder 0
    run_op(64'hFFFFFFFF00000000, 64'hFFFFFFFF00000000, lat);
    chk("R4 equal v0", v0_out, 64'hFFFFFFFEFFFFFFFF);
    chk("R4 equal v1", v1_out, 64'hFFFFFFFEFFFFFFFF);

    // R5: only lane 1 zero -> v0 loses only its quotient, v1 loses lane-0 remainder
    run_op(64'h0123456789ABCDEF, 64'h0, lat);
    begin
      logic [63:0] q0, r0;
      lane_ref(64'h0123456789ABCDEF, q0, r0);
      chk("R5 cross v0", v0_out, 64'h0123456789ABCDEF - q0);
      chk("R5 cross v1", v1_out, 64'h0 - r0);
    end

    // R8: hold, then start while busy ignored
    h0 = v0_out; h1 = v1_out;
    repeat (20) @(negedge clk);
    chk("R8 hold v0", v0_out, h0);
    chk("R8 hold v1", v1_out, h1);
    @(negedge clk); v0_in = VA[3]; v1_in = VB[3]; start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 1;
    chk("R9 busy after start", {63'd0, busy}, 64'd1);
    repeat (9) begin @(negedge clk); lat++; end
    v0_in = VA[6]; v1_in = VB[6]; start = 1'b1;
    @(negedge clk); start = 1'b0; lat++;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    model(VA[3], VB[3], ea, eb);
    chk("R8 ignored start v0", v0_out, ea);
    chk("R8 ignored start v1", v1_out, eb);
    chk("R8 latency unchanged", 64'(lat), 64'(LAT));
    chk("R9 busy low at done", {63'd0, busy}, 64'd0);
    repeat (LAT + 5) @(negedge clk);
    chk("R8 no second op", {63'd0, busy}, 64'd0);
    chk("R8 outputs kept", v0_out, ea);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule